// File: doc/BRIEF.md
# Bit-Weighted Pulse-Width Modulator

This block turns an 8-bit duty value into a pulse-width modulated output. A period is split into 256 equal segments. A segment counter steps through them, and each counter value selects at most one of eight pulse trains. Train k has 2^k segments per period. The output is high in the segments whose train belongs to a data bit that is set. The high time is therefore spread evenly across the period, rather than gathered into one block as a counter-compare modulator would do.

A prescaler builds the segment tick from the system clock. It first divides the clock by 2 to give a reference tick, then counts `SEG_TICKS` reference ticks per segment. A two-state controller gates the prescaler. In `ST_HALT` the prescaler and the counter freeze and the output rests at its inactive level. In `ST_RUN` they advance. The controller moves `ST_HALT -> ST_RUN` on `halt` low and `ST_RUN -> ST_HALT` on `halt` high. The data register is written through a simple write port, can be read back at any time, and feeds the decoder directly.

Top module: `pwm_bitweight`

## Requirements
- R1: One output period is 256 segments. Each segment is `SEG_TICKS` reference ticks, and a reference tick is 2 system clocks. A period is therefore 512*`SEG_TICKS` clocks.
- R2: When running with `invert`=0, the output is high for exactly D segments per period, where D is the data value.
- R3: With counter value c, data bit k (k = 7 down to 0) is active in the segments whose low 8-k bits of c are a 0 followed by 7-k ones. At most one bit is active in any segment.
- R4: With data 255 the output is high for 255 of 256 segments. In the segment where c = 255 it is never high.
- R5: With data 0 and `invert`=0 the output stays low for the whole period.
- R6: A write with `wr_en`=1 loads `wr_data`. The value shows on `rd_data` after the next clock edge and drives the pattern from that edge on.
- R7: With `invert`=1 the output is the complement of the pattern, so it is high for 256-D segments per period.
- R8: While `halt`=1, the block holds its counters and drives the output at its inactive level, which is the value of `invert`. After `halt` returns to 0, counting resumes and the high time per period is again exact.
- R9: Synchronous reset clears the data register, the counters and the output to 0, and puts the controller in `ST_HALT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | 1 stops the count source; 0 lets it run |
| invert | input | 1 | 1 selects the inverted output polarity |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Value to write into the data register |
| rd_data | output | 8 | Current contents of the data register |
| pwm_out | output | 1 | Modulated output |

## Verification
A data write can land in the same cycle as a segment tick, and a write can also coincide with a halt. The bench makes the first case happen by placing writes at random cycle offsets, so some fall on segment boundaries. It then sums the high cycles over a full period, and that sum must match the new value exactly. For the second case it writes while halted. There it checks that the readback updates while the output holds its inactive level, and that the new value is exact once the block resumes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int SEG_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic seg_tick
);
    localparam int TW = (SEG_TICKS > 1) ? $clog2(SEG_TICKS) : 1;
    localparam logic [TW-1:0] TLAST = TW'(SEG_TICKS - 1);

    logic          half_q;
    logic [TW-1:0] tcnt_q;
    logic          ref_tick;

    assign ref_tick = en && half_q;
    assign seg_tick = ref_tick && (tcnt_q == TLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
        end else if (en) begin
            half_q <= ~half_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt_q <= '0;
        end else if (ref_tick) begin
            tcnt_q <= (tcnt_q == TLAST) ? '0 : tcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_segcnt.sv
module pwm_segcnt #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [DW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_decode.sv
module pwm_decode #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cnt,
    output logic [DW-1:0] hit
);
    for (genvar k = 0; k < DW; k++) begin : g_bit
        localparam int W = DW - k;
        localparam logic [W-1:0] PAT = W'((1 << (W - 1)) - 1);
        assign hit[k] = (cnt[W-1:0] == PAT);
    end
endmodule

// File: rtl/pwm_bitweight.sv
module pwm_bitweight
    import pwm_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SEG_TICKS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          halt,
    input  logic          invert,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          pwm_out
);
    pwm_state_t    state_q, state_nx;
    logic [DW-1:0] data_q;
    logic [DW-1:0] seg_cnt;
    logic [DW-1:0] hit;
    logic          seg_tick;
    logic          level;
    logic          run;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HALT: if (!halt) state_nx = ST_RUN;
            ST_RUN:  if (halt)  state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_nx;
        end
    end

    assign run = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (wr_en) begin
            data_q <= wr_data;
        end
    end

    assign rd_data = data_q;

    pwm_prescale #(.SEG_TICKS(SEG_TICKS)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .en       (run),
        .seg_tick (seg_tick)
    );

    pwm_segcnt #(.DW(DW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .step (seg_tick),
        .cnt  (seg_cnt)
    );

    pwm_decode #(.DW(DW)) u_dec (
        .cnt (seg_cnt),
        .hit (hit)
    );

    assign level = |(hit & data_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_out <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN:  pwm_out <= level ^ invert;
                ST_HALT: pwm_out <= invert;
            endcase
        end
    end
endmodule

// File: rtl/pwm_bitweight_chk.sv
module pwm_bitweight_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          halt,
    input logic          invert,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] rd_data,
    input logic          pwm_out,
    input logic          run,
    input logic [DW-1:0] seg_cnt,
    input logic [DW-1:0] hit
);
    AST_ONE_TRAIN: assert property (@(posedge clk) disable iff (rst) $onehot0(hit)); // R3
    AST_NEVER_FULL: assert property (@(posedge clk) disable iff (rst)
        (seg_cnt == {DW{1'b1}}) |-> (hit == '0)); // R4
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (run && rd_data == '0 && !wr_en) |=> (pwm_out == $past(invert))); // R5
    AST_READBACK: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == $past(wr_data))); // R6
    AST_HALT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pwm_out == $past(invert))); // R8
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(seg_cnt)); // R8
endmodule

bind pwm_bitweight pwm_bitweight_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .halt    (halt),
    .invert  (invert),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pwm_out (pwm_out),
    .run     (run),
    .seg_cnt (seg_cnt),
    .hit     (hit)
);

// File: tb/sim_pwm_bitweight.sv
`timescale 1ns/1ps
module sim_pwm_bitweight;
    localparam int SEG_TICKS = 1;
    localparam int CPS       = 2 * SEG_TICKS;
    localparam int PERIOD    = 256 * CPS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt = 1'b0;
    logic       invert = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pwm_bitweight #(.DW(8), .SEG_TICKS(SEG_TICKS)) u0 (
        .clk(clk), .rst(rst), .halt(halt), .invert(invert),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    function automatic int exp_high(input int d, input logic inv);
        return inv ? (256 - d) * CPS : d * CPS;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 readback", int'(rd_data), int'(v));
    endtask

    task automatic measure(input string req, input int d);
        int hi = 0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check(req, hi, exp_high(d, invert));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, first_rise, second_rise, idx;
        logic prev;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R9 reset output", int'(pwm_out), 0);
        check("R9 reset data", int'(rd_data), 0);
        rst = 1'b0;

        // R5: zero data gives a low output
        measure("R5 zero data", 0);

        // R3: single-bit values give 2^k segments each
        for (int k = 0; k < 8; k++) begin
            write(8'(1 << k));
            measure("R3 single bit weight", 1 << k);
        end

        // R4: full-scale value never reaches 256/256
        write(8'd255);
        measure("R4 full scale", 255);

        // R1: the period length from rising edges with data 1
        write(8'd1);
        repeat (4) @(negedge clk);
        prev = pwm_out;
        first_rise = -1;
        second_rise = -1;
        idx = 0;
        while (second_rise < 0 && idx < 3 * PERIOD) begin
            @(negedge clk);
            idx++;
            if (pwm_out && !prev) begin
                if (first_rise < 0) first_rise = idx;
                else second_rise = idx;
            end
            prev = pwm_out;
        end
        check("R1 period length", second_rise - first_rise, PERIOD);

        // R2: random values written at random offsets
        for (int n = 0; n < 40; n++) begin
            repeat ($urandom % 37) @(negedge clk);
            v = int'($urandom % 256);
            write(8'(v));
            measure("R2 random duty", v);
        end

        // R7: inverted polarity
        invert = 1'b1;
        write(8'd0);
        measure("R7 inverted zero", 0);
        write(8'd255);
        measure("R7 inverted full", 255);
        for (int n = 0; n < 4; n++) begin
            v = int'($urandom % 256);
            write(8'(v));
            measure("R7 inverted random", v);
        end

        // R8: halt holds the output at its inactive level, for both polarities
        for (int p = 0; p < 2; p++) begin
            invert = p[0];
            write(8'd170);
            repeat ($urandom % 50) @(negedge clk);
            halt = 1'b1;
            repeat (3) @(negedge clk);
            v = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (pwm_out != invert) v++;
            end
            check("R8 halted output inactive", v, 0);
            write(8'd77);
            @(negedge clk);
            check("R8 halted output after write", int'(pwm_out), int'(invert));
            halt = 1'b0;
            measure("R8 resumed duty", 77);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule